// File: doc/BRIEF.md
# MDIO Management Master

This block drives a two-wire serial management bus from two software-visible registers. Software first writes a control word that opens a session and sets the management clock divisor and an optional preamble. It then writes a 32-bit frame word whose fields hold the start code, opcode, PHY address, register address, turnaround and write data. That write launches the frame. The block shifts the whole word out most-significant bit first on the data line, one bit per management-clock period, and raises a completion flag at the end.

On a read frame, the block stops driving the data line from the turnaround field onward. It samples the sixteen data bits that the PHY returns on rising clock edges. When the frame ends, it places them in the low half of the frame register. Writing zero to the control register closes the session, cuts off any frame in flight and releases the bus. The data line is split into an output value, an output enable and an input, so the pad tristate sits outside the block.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset both registers read zero, `mdc` is low and `mdio_oe` is low. The control register reads back as bits 6:0 divisor, bit 7 preamble enable, bit 8 done and zeros elsewhere. Bit 8 is read-only, so writing it has no effect.
- R2: A data-register write (`reg_sel`=1) while a session is open and no frame is active starts a frame. The frame carries all 32 bits of the written word, most-significant first, with one bit per MDC period. The frame word uses these fields: bits 31:30 start (01), bit 29 read, bit 28 write, 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data.
- R3: MDC has a period of 2×(divisor+1) clock cycles. It starts low, stays low whenever no frame is active, and MDIO and its enable change only while MDC is low.
- R4: When bit 7 of the control register is set, 32 driven ones come before the frame. With bit 7 clear, the frame starts at once.
- R5: When word bit 29 is set (read), `mdio_oe` is low for frame bits 17 down to 0. The 16 values of `mdio_in` sampled at the MDC rising edges of bits 15..0 are written into data-register bits 15:0 at completion, most-significant first. Bits 31:16 keep the written value.
- R6: When bit 29 is clear, the master drives all 32 frame bits, and the data register still reads the written word after completion.
- R7: The done flag (control bit 8) sets when the last bit's MDC period ends. It stays set while idle and clears in the cycle after a data write launches a new frame.
- R8: A control write of zero closes the session. It ends any active frame in the next cycle, with MDC low and MDIO released, and clears the done flag. No further MDC edges follow.
- R9: While a frame is active, data-register writes are ignored and nonzero control writes are ignored. The frame on the wire and both register readbacks are unchanged.
- R10: While no session is open (last control write was zero, or none since reset), a data-register write stores the word but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 frame data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Readback of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input from the pad |

## Verification
The hardest states to reach from the ports are register writes that land in the middle of a frame. One is a zero control write that must cut a preamble short. The other is a data or control write that must leave a running frame untouched. The stimulus reaches both by launching a frame and then writing a fixed number of cycles later, while MDC is still toggling. It then watches the wire and both readbacks. Read capture needs a PHY model that counts MDC rising edges on its own and presents each reply bit before the edge that samples it. The bench models the PHY this way across divisors 0 to 5, with the preamble both on and off.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_PRE, ENG_FRAME} eng_state_e;

  localparam int FRAME_BITS    = 32;
  localparam int POS_W         = $clog2(FRAME_BITS);
  localparam int RD_BITS       = 16;
  localparam int TA_POS        = 17;   // first turnaround bit of the frame word
  localparam int OPC_RD_POS    = 29;   // read opcode bit
  localparam int CTRL_PRE_POS  = 7;    // preamble enable in control register
  localparam int CTRL_DONE_POS = 8;    // done flag in control register

  // Clock cycles per MDC half period for a given divisor.
  function automatic int unsigned half_period(input int unsigned div);
    return div + 1;
  endfunction

  // Clock cycles per serial bit.
  function automatic int unsigned bit_period(input int unsigned div);
    return 2 * half_period(div);
  endfunction

  // True while the master owns the data line at frame position pos.
  function automatic logic master_drives(input logic is_rd, input logic [POS_W-1:0] pos);
    return !(is_rd && (pos <= POS_W'(TA_POS)));
  endfunction

  // True when frame position pos carries a read-data bit.
  function automatic logic is_data_bit(input logic [POS_W-1:0] pos);
    return pos < POS_W'(RD_BITS);
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
`timescale 1ns/1ps
module mgmt_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Named edge events: the rising one samples, the falling one advances.
  assign rise_tk = wrap && !mdc_q;
  assign fall_tk = wrap &&  mdc_q;
  assign mdc     = mdc_q && run;
endmodule

// File: rtl/mgmt_frame_engine.sv
`timescale 1ns/1ps
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 abort,
  input  logic [FRAME_BITS-1:0] word,
  input  logic                 pre_en,
  input  logic                 rise_tk,
  input  logic                 fall_tk,
  input  logic                 mdio_in,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 finish,
  output logic                 is_rd,
  output logic [RD_BITS-1:0]   rd_data
);
  localparam int PRE_CW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;

  eng_state_e            st_q;
  logic [PRE_CW-1:0]     pre_q;
  logic [POS_W-1:0]      pos_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  rd_q;
  logic [RD_BITS-1:0]    cap_q;
  logic                  drive_now;
  logic                  pre_last;
  logic                  frame_last;

  assign busy       = (st_q != ENG_IDLE);
  assign pre_last   = (pre_q == '0);
  assign frame_last = (pos_q == '0);
  assign finish     = (st_q == ENG_FRAME) && fall_tk && frame_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      pre_q <= '0;
      pos_q <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else if (abort) begin
      st_q <= ENG_IDLE;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (launch) begin
            st_q  <= pre_en ? ENG_PRE : ENG_FRAME;
            sh_q  <= word;
            pos_q <= POS_W'(FRAME_BITS - 1);
            pre_q <= PRE_CW'(PRE_LEN - 1);
            rd_q  <= word[OPC_RD_POS];
            cap_q <= '0;
          end
        end
        ENG_PRE: begin
          if (fall_tk) begin
            if (pre_last) st_q <= ENG_FRAME;
            else          pre_q <= pre_q - 1'b1;
          end
        end
        ENG_FRAME: begin
          if (rise_tk && rd_q && is_data_bit(pos_q))
            cap_q <= {cap_q[RD_BITS-2:0], mdio_in};
          if (fall_tk) begin
            if (frame_last) begin
              st_q <= ENG_IDLE;
            end else begin
              pos_q <= pos_q - 1'b1;
              sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign drive_now = (st_q == ENG_PRE) ||
                     ((st_q == ENG_FRAME) && master_drives(rd_q, pos_q));
  assign mdio_oe   = drive_now;
  assign mdio_o    = (st_q == ENG_PRE) ||
                     ((st_q == ENG_FRAME) && drive_now && sh_q[FRAME_BITS-1]);
  assign is_rd     = rd_q;
  assign rd_data   = cap_q;
endmodule

// File: rtl/mgmt_serial_master.sv
`timescale 1ns/1ps
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [DIV_W-1:0]   div_q;
  logic               pre_en_q;
  logic               en_q;
  logic               done_q;
  logic [31:0]        data_q;
  logic [31:0]        ctrl_view;

  logic               ctrl_wr;
  logic               data_wr;
  logic               kill;
  logic               launch;
  logic               busy;
  logic               finish;
  logic               is_rd;
  logic [RD_BITS-1:0] rd_data;
  logic               rise_tk;
  logic               fall_tk;

  assign ctrl_wr = reg_we && !reg_sel;
  assign data_wr = reg_we &&  reg_sel;
  assign kill    = ctrl_wr && (reg_wdata == 32'd0);
  assign launch  = data_wr && en_q && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      pre_en_q <= 1'b0;
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (data_wr && !busy)
        data_q <= reg_wdata;
      if (launch)
        done_q <= 1'b0;
      if (finish) begin
        done_q <= 1'b1;
        if (is_rd) data_q[RD_BITS-1:0] <= rd_data;
      end
      if (ctrl_wr && (!busy || kill)) begin
        div_q    <= reg_wdata[DIV_W-1:0];
        pre_en_q <= reg_wdata[CTRL_PRE_POS];
        en_q     <= |reg_wdata;
        if (kill) done_q <= 1'b0;
      end
    end
  end

  generate
    if (DIV_W < CTRL_PRE_POS) begin : g_pad
      assign ctrl_view = {23'd0, done_q, pre_en_q, {(CTRL_PRE_POS-DIV_W){1'b0}}, div_q};
    end else begin : g_full
      assign ctrl_view = {23'd0, done_q, pre_en_q, div_q};
    end
  endgenerate

  assign reg_rdata = reg_sel ? data_q : ctrl_view;

  mgmt_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .div     (div_q),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mgmt_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .abort   (kill),
    .word    (reg_wdata),
    .pre_en  (pre_en_q),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk),
    .mdio_in (mdio_in),
    .busy    (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .finish  (finish),
    .is_rd   (is_rd),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/mgmt_serial_master_checks.sv
`timescale 1ns/1ps
module mgmt_serial_master_checks #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_we,
  input logic [31:0]      reg_wdata,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             launch,
  input logic             finish,
  input logic             done_q,
  input logic             en_q,
  input logic             pre_en_q,
  input logic [DIV_W-1:0] div_q
);
  p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_mdio_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_oe_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  p_launch_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!done_q && busy));

  p_done_from_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(finish));

  p_kill_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel && (reg_wdata == 32'd0)) |=> (!busy && !mdio_oe && !mdc && !done_q));

  p_cfg_held_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && !reg_sel && (reg_wdata != 32'd0)) |=>
      ((div_q == $past(div_q)) && (pre_en_q == $past(pre_en_q))));

  p_closed_no_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !busy);
endmodule

bind mgmt_serial_master mgmt_serial_master_checks #(.DIV_W(DIV_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (busy),
  .launch    (launch),
  .finish    (finish),
  .done_q    (done_q),
  .en_q      (en_q),
  .pre_en_q  (pre_en_q),
  .div_q     (div_q)
);

// File: tb/mgmt_serial_master_test.sv
`timescale 1ns/1ps
module mgmt_serial_master_test;
  localparam real CLK_NS = 4.0;
  localparam int  NVEC   = 6;
  // {control 9b, frame word 32b, PHY reply 16b}
  localparam logic [56:0] VECS [NVEC] = '{
    {9'h002, 32'h528EBEEF, 16'h0000},
    {9'h002, 32'h6F860000, 16'hC0A5},
    {9'h083, 32'h617E1234, 16'h8001},
    {9'h080, 32'h5EFE4000, 16'h0000},
    {9'h100, 32'h60020000, 16'hFFFF},
    {9'h005, 32'h58420001, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_in = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          ended = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mgmt_serial_master uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  // Count MDC rising edges over n cycles.
  task automatic count_rises(input int n, output int r);
    logic pm;
    r = 0; pm = mdc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mdc && !pm) r++;
      pm = mdc;
    end
  endtask

  task automatic wait_done(input int lim, output int cyc, output logic seen);
    seen = 1'b0; cyc = 0; reg_sel = 1'b0;
    while (!seen && cyc < lim) begin
      @(negedge clk); cyc++;
      if (reg_rdata[8]) seen = 1'b1;
    end
  endtask

  task automatic run_frame(input logic [8:0] cv, input logic [31:0] w, input logic [15:0] rp);
    int dv, plen, nb, k, cyc, last_rise, bit_err, per_err, pos;
    logic rd, pm, seen, eo, ed;
    logic [31:0] v, expd;
    dv = int'(cv[6:0]); plen = cv[7] ? 32 : 0; nb = plen + 32; rd = w[29];
    mdio_in = 1'b0;
    wr_reg(1'b0, {23'd0, cv});
    wr_reg(1'b1, w);
    rd_reg(1'b0, v);
    check(v[8] == 1'b0, "R7 done cleared at launch", v, 32'd0);
    k = 0; cyc = 0; last_rise = -1; bit_err = 0; per_err = 0; seen = 1'b0; pm = mdc;
    while (!seen && cyc < 2000) begin
      @(negedge clk); cyc++;
      if (mdc && !pm) begin
        if (k < plen) begin eo = 1'b1; ed = 1'b1; end
        else begin pos = 31 - (k - plen); eo = !(rd && pos <= 17); ed = w[pos]; end
        if (mdio_oe !== eo) bit_err++;
        else if (eo && (mdio_o !== ed)) bit_err++;
        if (last_rise >= 0 && (cyc - last_rise) != 2 * (dv + 1)) per_err++;
        last_rise = cyc; k++;
        if (rd && k >= plen && k < nb) begin
          pos = 31 - (k - plen);
          if (pos < 16) mdio_in = rp[pos];
        end
      end
      pm = mdc;
      if (reg_rdata[8]) seen = 1'b1;
    end
    check(seen, "R7 done flag set at end of frame", 32'(seen), 32'd1);
    check(k == nb, "R2 R4 number of serial bits", k, nb);
    check(bit_err == 0, rd ? "R2 R4 R5 wire pattern of read frame" : "R2 R4 R6 wire pattern of write frame", bit_err, 0);
    check(per_err == 0, "R3 MDC period", per_err, 0);
    check(!mdc && !mdio_oe, "R3 bus idle after frame", {mdc, mdio_oe}, 0);
    expd = rd ? {w[31:16], rp} : w;
    rd_reg(1'b1, v);
    check(v == expd, rd ? "R5 captured read data" : "R6 data register after write", v, expd);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r, cyc;
    logic seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(1'b0, v); check(v == 32'd0, "R1 control after reset", v, 0);
    rd_reg(1'b1, v); check(v == 32'd0, "R1 data after reset", v, 0);
    check(!mdc && !mdio_oe, "R1 bus idle after reset", {mdc, mdio_oe}, 0);
    // R1 layout, done bit read-only
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, v); check(v == 32'h0000_00FF, "R1 control readback fields", v, 32'hFF);
    wr_reg(1'b0, 32'd0);

    // R10 closed session: data stored, no frame
    wr_reg(1'b1, 32'h528EBEEF);
    count_rises(60, r);
    check(r == 0, "R10 no MDC while session closed", r, 0);
    rd_reg(1'b1, v); check(v == 32'h528EBEEF, "R10 data stored while closed", v, 32'h528EBEEF);

    // Vector table
    for (int i = 0; i < NVEC; i++)
      run_frame(VECS[i][56:48], VECS[i][47:16], VECS[i][15:0]);

    // R9 writes during a frame are ignored
    wr_reg(1'b0, 32'h002);
    wr_reg(1'b1, 32'h528EBEEF);
    repeat (20) @(negedge clk);
    wr_reg(1'b1, 32'h6F860000);
    wr_reg(1'b0, 32'h085);
    rd_reg(1'b1, v); check(v == 32'h528EBEEF, "R9 data write ignored while busy", v, 32'h528EBEEF);
    rd_reg(1'b0, v); check(v[8:0] == 9'h002, "R9 control write ignored while busy", v, 32'h002);
    wait_done(400, cyc, seen);
    check(seen && cyc <= 192, "R9 original frame length kept", cyc, 192);
    rd_reg(1'b1, v); check(v == 32'h528EBEEF, "R9 data after undisturbed frame", v, 32'h528EBEEF);

    // R8 zero write clears done when idle
    wr_reg(1'b0, 32'd0);
    rd_reg(1'b0, v); check(v == 32'd0, "R8 close clears done", v, 0);

    // R8 abort in the middle of a preamble
    wr_reg(1'b0, 32'h083);
    wr_reg(1'b1, 32'h617E1234);
    repeat (30) @(negedge clk);
    wr_reg(1'b0, 32'd0);
    #1;
    check(!mdc && !mdio_oe, "R8 bus released after close", {mdc, mdio_oe}, 0);
    rd_reg(1'b0, v); check(v == 32'd0, "R8 control after close", v, 0);
    count_rises(300, r);
    check(r == 0, "R8 no MDC edges after close", r, 0);
    rd_reg(1'b1, v); check(v == 32'h617E1234, "R8 aborted read leaves data", v, 32'h617E1234);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule